// File: doc/BRIEF.md
# Load Outcome Resolver

This block settles what happens to a load in its second pipeline cycle. It sees the load's byte mask within a 64-bit doubleword and whether it targets I/O space. It also sees, for every store-queue entry, the result of a snoop against the load: a doubleword address match, the entry's byte mask and data, a fence flag, and the entry's hazard bitmask. The hazard bitmask has bit j set when entry j must complete before that entry. A data-cache hit flag and the cache's doubleword complete the inputs.

The block picks exactly one of three outcomes and registers it: complete with data forwarded from a store, complete with cache data, or push into the store queue. When it pushes the load, it also supplies the hazard mask that the new entry must wait on. A store is treated as newest when its hazard bits cover every other overlapping store, so the choice does not depend on slot position. Fences and partially covering stores make the load queue instead of stalling.

Top module: `load_resolve`

## Requirements
- R1: After reset, `res_kind`, `res_data` and `res_haz` are all zero.
- R2: A valid load with `ld_io` set always gives the queue outcome (`res_kind` = 3'b100), whatever the cache and snoop inputs are.
- R3: A valid load while any entry has its fence flag set gives the queue outcome, and every fence entry's bit is set in `res_haz`.
- R4: An entry overlaps the load when `sq_match` is set, the fence flag is clear, and its byte mask shares at least one byte with `ld_mask`. A non-I/O, fence-free load chooses the forward outcome (`res_kind` = 3'b001) when the newest overlapping entry's mask covers every byte of `ld_mask`. `res_data` then holds that entry's data in the lanes set in `ld_mask` (byte b = bits 8b+7..8b) and zeros elsewhere.
- R5: When several entries overlap, the entry forwarded is the one whose hazard bits cover all the other overlapping entries. Slot index plays no part.
- R6: When the newest overlapping entry does not cover all load bytes, the load gets the queue outcome.
- R7: With no overlap, no fence and no I/O, a cache hit gives the cache outcome (`res_kind` = 3'b010) and `res_data` is the cache data masked to the load lanes. Matching entries that share no bytes with the load have no effect.
- R8: With no overlap, no fence and no I/O, a cache miss gives the queue outcome.
- R9: On the queue outcome, `res_haz` is the OR of the overlapping entries and the fence entries. On other outcomes `res_haz` and, for queue, `res_data` are zero.
- R10: Results appear one clock after the inputs. `res_kind` is one-hot for a valid load and zero when `ld_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load is present this cycle |
| ld_io | input | 1 | Load targets I/O space |
| ld_mask | input | DW/8 | Bytes read by the load |
| sq_match | input | NSQ | Per entry: valid and same doubleword |
| sq_fence | input | NSQ | Per entry: valid fence |
| sq_mask | input | NSQ*DW/8 | Per entry byte masks, entry i at [i*DW/8 +: DW/8] |
| sq_data | input | NSQ*DW | Per entry store data, lane aligned |
| sq_haz | input | NSQ*NSQ | Per entry hazard bits, entry i at [i*NSQ +: NSQ] |
| dc_hit | input | 1 | Data cache hit |
| dc_data | input | DW | Data cache doubleword |
| res_kind | output | 3 | One-hot: bit0 forward, bit1 cache, bit2 queue |
| res_data | output | DW | Completed load data |
| res_haz | output | NSQ | Hazard mask for the queued entry |

## Verification
The assertions and the forwarding logic assume that the hazard bitmasks describe a strict age order among live entries. Each entry's bits then name exactly the entries older than it, so at most one overlapping entry can cover all the others. The stimulus builds every hazard mask from an age permutation of the entries, using rotations and reversals of the slot order, so this assumption always holds. Within that, it sweeps every match pattern against several load and store mask shapes, fence placements, cache hit and I/O settings.

// File: rtl/load_resolve.sv
module load_resolve #(
  parameter int NSQ = 4,
  parameter int DW  = 64,
  localparam int BW = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic              ld_io,
  input  logic [BW-1:0]     ld_mask,
  input  logic [NSQ-1:0]    sq_match,
  input  logic [NSQ-1:0]    sq_fence,
  input  logic [NSQ*BW-1:0] sq_mask,
  input  logic [NSQ*DW-1:0] sq_data,
  input  logic [NSQ*NSQ-1:0] sq_haz,
  input  logic              dc_hit,
  input  logic [DW-1:0]     dc_data,
  output logic [2:0]        res_kind,
  output logic [DW-1:0]     res_data,
  output logic [NSQ-1:0]    res_haz
);
  localparam logic [2:0] K_FWD = 3'b001;
  localparam logic [2:0] K_DC  = 3'b010;
  localparam logic [2:0] K_Q   = 3'b100;

  logic [NSQ-1:0] ovl, newest;
  logic [BW-1:0]  sel_mask;
  logic [DW-1:0]  sel_data, lanes;
  logic [2:0]     kind_d;

  for (genvar b = 0; b < BW; b++) begin : g_lane
    assign lanes[b*8 +: 8] = {8{ld_mask[b]}};
  end

  for (genvar i = 0; i < NSQ; i++) begin : g_ent
    assign ovl[i] = sq_match[i] & ~sq_fence[i] & (|(sq_mask[i*BW +: BW] & ld_mask));
    assign newest[i] = ovl[i] &
      (((sq_haz[i*NSQ +: NSQ] | (NSQ'(1) << i)) & ovl) == ovl);
  end

  always_comb begin
    sel_mask = '0;
    sel_data = '0;
    for (int i = 0; i < NSQ; i++)
      if (newest[i]) begin
        sel_mask |= sq_mask[i*BW +: BW];
        sel_data |= sq_data[i*DW +: DW];
      end
  end

  always_comb begin
    if (!ld_valid)                 kind_d = 3'b000;
    else if (ld_io || |sq_fence)   kind_d = K_Q;
    else if (|ovl)
      kind_d = ($countones(newest) == 1 && (sel_mask & ld_mask) == ld_mask) ? K_FWD : K_Q;
    else                           kind_d = dc_hit ? K_DC : K_Q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_kind <= '0;
      res_data <= '0;
      res_haz  <= '0;
    end else begin
      res_kind <= kind_d;
      res_data <= kind_d[0] ? (sel_data & lanes) :
                  kind_d[1] ? (dc_data & lanes) : '0;
      res_haz  <= kind_d[2] ? (ovl | sq_fence) : '0;
    end
  end

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_kind));
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> res_kind == 3'b000);
  a_r2_io_queues: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_io |=> res_kind == K_Q);
  a_r3_fence_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && |sq_fence |=> res_kind == K_Q && (res_haz & $past(sq_fence)) == $past(sq_fence));
  a_r9_haz_only_queue: assert property (@(posedge clk) disable iff (!rst_n)
    !res_kind[2] |-> res_haz == '0);
endmodule

// File: tb/test_load_resolve.sv
`timescale 1ns/1ps
module test_load_resolve;
  localparam int NSQ = 4, DW = 64, BW = 8;
  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, ld_io = 0, dc_hit = 0;
  logic [BW-1:0] ld_mask = '0;
  logic [NSQ-1:0] sq_match = '0, sq_fence = '0;
  logic [NSQ*BW-1:0] sq_mask = '0;
  logic [NSQ*DW-1:0] sq_data = '0;
  logic [NSQ*NSQ-1:0] sq_haz = '0;
  logic [DW-1:0] dc_data = '0;
  logic [2:0] res_kind;
  logic [DW-1:0] res_data;
  logic [NSQ-1:0] res_haz;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  load_resolve #(.NSQ(NSQ), .DW(DW)) i_load_resolve (
    .clk, .rst_n, .ld_valid, .ld_io, .ld_mask, .sq_match, .sq_fence,
    .sq_mask, .sq_data, .sq_haz, .dc_hit, .dc_data,
    .res_kind, .res_data, .res_haz);

  function automatic logic [DW-1:0] expand(logic [BW-1:0] m);
    logic [DW-1:0] r;
    for (int b = 0; b < BW; b++) r[b*8 +: 8] = {8{m[b]}};
    return r;
  endfunction

  task automatic check(string tag, logic [2:0] ek, logic [DW-1:0] ed, logic [NSQ-1:0] eh);
    nvec++;
    if (res_kind !== ek || res_data !== ed || res_haz !== eh) begin
      nbad++;
      $display("FAIL %s: kind=%b data=%h haz=%b expected kind=%b data=%h haz=%b",
               tag, res_kind, res_data, res_haz, ek, ed, eh);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lms [6] = '{8'hFF, 8'h0F, 8'hF0, 8'h01, 8'h3C, 8'h80};
    repeat (3) @(posedge clk);
    #1 check("R1", 3'b000, '0, '0);
    @(negedge clk) rst_n = 1;
    for (int rot = 0; rot < 8; rot++)
      for (int hp = 0; hp < 16; hp++)
        for (int k = 0; k < 4; k++)
          for (int li = 0; li < 6; li++) begin
            int age [NSQ];
            logic [NSQ-1:0] ov, fen, hz;
            logic [2:0] ek;
            logic [DW-1:0] ed;
            string tag;
            int best;
            @(negedge clk);
            for (int i = 0; i < NSQ; i++) begin
              age[i] = rot < 4 ? (i + rot) % NSQ : (NSQ - 1 - i + rot) % NSQ;
              sq_mask[i*BW +: BW] = lms[(i + hp + k + rot) % 6];
              sq_data[i*DW +: DW] = {8{8'(8'h11 * (i + 1) + rot)}} ^ {32'h0, 32'(hp * 977)};
            end
            for (int i = 0; i < NSQ; i++)
              for (int j = 0; j < NSQ; j++)
                sq_haz[i*NSQ + j] = age[j] < age[i];
            fen = (k == 3) ? NSQ'(1) << (hp % NSQ) : '0;
            sq_match = NSQ'(hp);
            sq_fence = fen;
            ld_mask = lms[li];
            ld_io = (k == 2 && li == 5);
            ld_valid = !(hp == 5 && li == 0);
            dc_hit = k[0];
            dc_data = 64'hC0DE_0000_0000_0000 | 64'(rot * 4096 + hp * 64 + li);
            ov = '0;
            best = -1;
            for (int i = 0; i < NSQ; i++) begin
              ov[i] = sq_match[i] && !fen[i] && |(sq_mask[i*BW +: BW] & ld_mask);
              if (ov[i] && (best < 0 || age[i] > age[best])) best = i;
            end
            hz = ov | fen;
            ed = '0;
            if (!ld_valid) begin ek = 3'b000; hz = '0; tag = "R10"; end
            else if (ld_io) begin ek = 3'b100; tag = "R2"; end
            else if (|fen) begin ek = 3'b100; tag = "R3"; end
            else if (|ov) begin
              if ((sq_mask[best*BW +: BW] & ld_mask) == ld_mask) begin
                ek = 3'b001; hz = '0;
                ed = sq_data[best*DW +: DW] & expand(ld_mask);
                tag = ($countones(ov) > 1) ? "R5" : "R4";
              end else begin ek = 3'b100; tag = "R6"; end
            end
            else if (dc_hit) begin ek = 3'b010; hz = '0; ed = dc_data & expand(ld_mask); tag = "R7"; end
            else begin ek = 3'b100; tag = "R8"; end
            @(posedge clk);
            #1 check({tag, "/R9"}, ek, ed, hz);
          end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule